// File: doc/BRIEF.md
# ASID-Tagged Translation Cache with Invalidation

This block is a small fully associative cache for finished address translations. Every line is tagged with an address-space identifier (ASID) and an input virtual address. A lookup compares the query against all valid lines in the same cycle and returns hit or miss. On a hit it also returns the stored output address, address mask and permission bits. When a page-table walk finishes, its result is written in through the fill port.

Software or a command queue keeps the cache coherent through a maintenance port. That port carries three invalidation scopes: every line, every line of one ASID, or the single line holding one ASID/address pair. A fill goes first to a line that already holds the same key. Failing that, it goes to the lowest free line. Only when the cache is full does it replace the line named by a round-robin pointer.

Top module: `iotlb_cache`

## Requirements
- R1: While `rst_n` is low, every line is emptied and the replacement pointer returns to line 0, so every lookup after reset misses.
- R2: A lookup hits only if a valid line matches both the ASID and the full input address exactly. The hit and the stored output address, mask and permissions appear combinationally in the same cycle.
- R3: On a miss, `lk_out_addr`, `lk_mask` and `lk_perm` are all zero.
- R4: A fill sampled at a rising edge can be seen by lookups from that edge onward.
- R5: An invalidation with `inv_kind` = 2'b00 removes every line.
- R6: An invalidation with `inv_kind` = 2'b01 removes every line whose ASID equals `inv_asid`, whatever its address. Lines of other ASIDs stay.
- R7: An invalidation with `inv_kind` = 2'b10 removes only the line whose ASID and address both equal `inv_asid`/`inv_addr`.
- R8: An invalidation with `inv_kind` = 2'b11 has no effect.
- R9: A fill whose key is already cached overwrites that line in place, so a key never occupies two lines.
- R10: A fill of a new key goes into the lowest-numbered free line and leaves the replacement pointer unchanged.
- R11: A fill of a new key into a full cache replaces the line at the replacement pointer. The pointer then advances by one and wraps from the last line to line 0.
- R12: When an invalidation and a fill arrive in the same cycle, the invalidation is applied first and the fill is then placed against the remaining lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_asid | input | ASID_W | Lookup ASID |
| lk_addr | input | VA_W | Lookup input address |
| lk_hit | output | 1 | Lookup hit |
| lk_out_addr | output | OA_W | Translated address of the hit line |
| lk_mask | output | VA_W | Address mask of the hit line |
| lk_perm | output | PERM_W | Permission bits of the hit line |
| fl_valid | input | 1 | Fill request |
| fl_asid | input | ASID_W | Fill ASID |
| fl_addr | input | VA_W | Fill input address |
| fl_out_addr | input | OA_W | Fill translated address |
| fl_mask | input | VA_W | Fill address mask |
| fl_perm | input | PERM_W | Fill permission bits |
| inv_valid | input | 1 | Invalidation request |
| inv_kind | input | 2 | Scope: 00 all, 01 by ASID, 10 by ASID and address, 11 none |
| inv_asid | input | ASID_W | Invalidation ASID |
| inv_addr | input | VA_W | Invalidation address |

## Verification
Invalidation and fill are the two functions that can land in the same edge. The bench provokes this by raising both requests in one cycle in three cases. In the first, an invalidate-all on a full cache is paired with a fill of a new key. In the second, a single-pair invalidation names the very key being refilled with new data. In the third, an ASID invalidation is paired with a fill that carries the same ASID. Each case is judged through lookups afterwards: the filled key must hit with the new data, the invalidated keys must miss, and the fill must land in a line freed by the invalidation rather than evict a survivor.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;

    typedef enum logic [1:0] {
        INV_ALL  = 2'b00,
        INV_ASID = 2'b01,
        INV_PAIR = 2'b10,
        INV_NOP  = 2'b11
    } inv_kind_e;

endpackage

// File: rtl/iotlb_keymatch.sv
module iotlb_keymatch #(
    parameter int N      = 8,
    parameter int ASID_W = 16,
    parameter int VA_W   = 64
) (
    input  logic [N-1:0]             valid,
    input  logic [N-1:0][ASID_W-1:0] line_asid,
    input  logic [N-1:0][VA_W-1:0]   line_va,
    input  logic [ASID_W-1:0]        q_asid,
    input  logic [VA_W-1:0]          q_va,
    output logic [N-1:0]             hit_asid,
    output logic [N-1:0]             hit_pair
);

    for (genvar g = 0; g < N; g++) begin : g_line
        assign hit_asid[g] = valid[g] && (line_asid[g] == q_asid);
        assign hit_pair[g] = hit_asid[g] && (line_va[g] == q_va);
    end

endmodule

// File: rtl/iotlb_pick.sv
module iotlb_pick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     same_key,
    input  logic [N-1:0]     valid,
    input  logic [IDX_W-1:0] rr,
    output logic [IDX_W-1:0] idx,
    output logic             take_rr
);

    logic [IDX_W-1:0] key_idx, free_idx;
    logic             any_key, any_free;

    always_comb begin
        key_idx  = '0;
        free_idx = '0;
        any_key  = 1'b0;
        any_free = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (same_key[i]) begin
                key_idx = IDX_W'(i);
                any_key = 1'b1;
            end
            if (!valid[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
        take_rr = 1'b0;
        if (any_key) begin
            idx = key_idx;
        end else if (any_free) begin
            idx = free_idx;
        end else begin
            idx     = rr;
            take_rr = 1'b1;
        end
    end

endmodule

// File: rtl/iotlb_cache.sv
module iotlb_cache
    import iotlb_pkg::*;
#(
    parameter int N      = 8,
    parameter int ASID_W = 16,
    parameter int VA_W   = 64,
    parameter int OA_W   = 64,
    parameter int PERM_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VA_W-1:0]   lk_addr,
    output logic              lk_hit,
    output logic [OA_W-1:0]   lk_out_addr,
    output logic [VA_W-1:0]   lk_mask,
    output logic [PERM_W-1:0] lk_perm,
    input  logic              fl_valid,
    input  logic [ASID_W-1:0] fl_asid,
    input  logic [VA_W-1:0]   fl_addr,
    input  logic [OA_W-1:0]   fl_out_addr,
    input  logic [VA_W-1:0]   fl_mask,
    input  logic [PERM_W-1:0] fl_perm,
    input  logic              inv_valid,
    input  logic [1:0]        inv_kind,
    input  logic [ASID_W-1:0] inv_asid,
    input  logic [VA_W-1:0]   inv_addr
);

    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    typedef struct packed {
        logic [N-1:0]             valid;
        logic [N-1:0][ASID_W-1:0] asid;
        logic [N-1:0][VA_W-1:0]   va;
        logic [N-1:0][OA_W-1:0]   oa;
        logic [N-1:0][VA_W-1:0]   mask;
        logic [N-1:0][PERM_W-1:0] perm;
        logic [IDX_W-1:0]         rr;
    } state_t;

    state_t s_q, s_d;

    logic [N-1:0] lk_vec, lk_asid_unused;
    logic [N-1:0] inv_asid_vec, inv_pair_vec;
    logic [N-1:0] fl_asid_unused, fl_vec;
    logic [N-1:0] kill, valid_mid;
    logic [IDX_W-1:0] vic_idx;
    logic             vic_rr;

    iotlb_keymatch #(.N(N), .ASID_W(ASID_W), .VA_W(VA_W)) u_lk_match (
        .valid(s_q.valid), .line_asid(s_q.asid), .line_va(s_q.va),
        .q_asid(lk_asid), .q_va(lk_addr),
        .hit_asid(lk_asid_unused), .hit_pair(lk_vec)
    );

    iotlb_keymatch #(.N(N), .ASID_W(ASID_W), .VA_W(VA_W)) u_inv_match (
        .valid(s_q.valid), .line_asid(s_q.asid), .line_va(s_q.va),
        .q_asid(inv_asid), .q_va(inv_addr),
        .hit_asid(inv_asid_vec), .hit_pair(inv_pair_vec)
    );

    // Invalidation resolves before the fill is placed.
    always_comb begin
        kill = '0;
        if (inv_valid) begin
            case (inv_kind_e'(inv_kind))
                INV_ALL:  kill = '1;
                INV_ASID: kill = inv_asid_vec;
                INV_PAIR: kill = inv_pair_vec;
                default:  kill = '0;
            endcase
        end
        valid_mid = s_q.valid & ~kill;
    end

    iotlb_keymatch #(.N(N), .ASID_W(ASID_W), .VA_W(VA_W)) u_fl_match (
        .valid(valid_mid), .line_asid(s_q.asid), .line_va(s_q.va),
        .q_asid(fl_asid), .q_va(fl_addr),
        .hit_asid(fl_asid_unused), .hit_pair(fl_vec)
    );

    iotlb_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
        .same_key(fl_vec), .valid(valid_mid), .rr(s_q.rr),
        .idx(vic_idx), .take_rr(vic_rr)
    );

    always_comb begin
        s_d       = s_q;
        s_d.valid = valid_mid;
        if (fl_valid) begin
            s_d.valid[vic_idx] = 1'b1;
            s_d.asid[vic_idx]  = fl_asid;
            s_d.va[vic_idx]    = fl_addr;
            s_d.oa[vic_idx]    = fl_out_addr;
            s_d.mask[vic_idx]  = fl_mask;
            s_d.perm[vic_idx]  = fl_perm;
            if (vic_rr) begin
                s_d.rr = (s_q.rr == LAST) ? '0 : s_q.rr + 1'b1;
            end
        end
        if (!rst_n) begin
            s_d.valid = '0;
            s_d.rr    = '0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    always_comb begin
        lk_out_addr = '0;
        lk_mask     = '0;
        lk_perm     = '0;
        for (int i = 0; i < N; i++) begin
            if (lk_vec[i]) begin
                lk_out_addr = lk_out_addr | s_q.oa[i];
                lk_mask     = lk_mask | s_q.mask[i];
                lk_perm     = lk_perm | s_q.perm[i];
            end
        end
        lk_hit = |lk_vec;
    end

    // ---------------- assertions ----------------
    a_r9_single_line_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_vec));

    a_r9_single_fill_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fl_vec));

    a_r4_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
        fl_valid |=> s_q.valid[$past(vic_idx)] && s_q.va[$past(vic_idx)] == $past(fl_addr)
                     && s_q.asid[$past(vic_idx)] == $past(fl_asid));

    a_r5_all_gone: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid && inv_kind == 2'b00 && !fl_valid |=> s_q.valid == '0);

    a_r8_nop_kind: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid && inv_kind == 2'b11 && !fl_valid |=> $stable(s_q.valid));

    a_r10_rr_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        fl_valid && vic_rr |-> &valid_mid);

    a_r11_rr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_valid |=> $stable(s_q.rr));

    a_r12_no_silent_loss: assert property (@(posedge clk) disable iff (!rst_n)
        !inv_valid |=> $countones(s_q.valid) >= $past($countones(s_q.valid)));

    for (genvar g = 0; g < N; g++) begin : g_chk
        a_r6_asid_cleared: assert property (@(posedge clk) disable iff (!rst_n)
            inv_valid && inv_kind == 2'b01 && !(fl_valid && fl_asid == inv_asid)
            |=> !(s_q.valid[g] && s_q.asid[g] == $past(inv_asid)));

        a_r7_pair_cleared: assert property (@(posedge clk) disable iff (!rst_n)
            inv_valid && inv_kind == 2'b10
            && !(fl_valid && fl_asid == inv_asid && fl_addr == inv_addr)
            |=> !(s_q.valid[g] && s_q.asid[g] == $past(inv_asid)
                  && s_q.va[g] == $past(inv_addr)));
    end

endmodule

// File: tb/sim_iotlb_cache.sv
module sim_iotlb_cache;

    localparam int CLK_P = 10;
    localparam int WD    = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] lk_asid;
    logic [63:0] lk_addr;
    logic        lk_hit;
    logic [63:0] lk_out_addr;
    logic [63:0] lk_mask;
    logic [1:0]  lk_perm;
    logic        fl_valid;
    logic [15:0] fl_asid;
    logic [63:0] fl_addr;
    logic [63:0] fl_out_addr;
    logic [63:0] fl_mask;
    logic [1:0]  fl_perm;
    logic        inv_valid;
    logic [1:0]  inv_kind;
    logic [15:0] inv_asid;
    logic [63:0] inv_addr;

    int checks = 0;
    int fails  = 0;

    always #(CLK_P / 2) clk = ~clk;

    iotlb_cache u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_asid(lk_asid), .lk_addr(lk_addr), .lk_hit(lk_hit),
        .lk_out_addr(lk_out_addr), .lk_mask(lk_mask), .lk_perm(lk_perm),
        .fl_valid(fl_valid), .fl_asid(fl_asid), .fl_addr(fl_addr),
        .fl_out_addr(fl_out_addr), .fl_mask(fl_mask), .fl_perm(fl_perm),
        .inv_valid(inv_valid), .inv_kind(inv_kind),
        .inv_asid(inv_asid), .inv_addr(inv_addr)
    );

    function automatic logic [15:0] ka(int i);
        return 16'h0100 + 16'(i);
    endfunction
    function automatic logic [63:0] kv(int i);
        return 64'h0000_1000_0000_0000 + (64'(i) << 12);
    endfunction
    function automatic logic [63:0] ko(int i);
        return 64'h0000_0000_A000_0000 + (64'(i) << 12);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; fl_valid = 1'b0; inv_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic set_fill(logic [15:0] a, logic [63:0] v, logic [63:0] o, logic [1:0] p);
        fl_valid = 1'b1; fl_asid = a; fl_addr = v;
        fl_out_addr = o; fl_mask = 64'hFFF; fl_perm = p;
    endtask

    task automatic fill(logic [15:0] a, logic [63:0] v, logic [63:0] o, logic [1:0] p);
        @(negedge clk);
        set_fill(a, v, o, p);
        @(negedge clk);
        fl_valid = 1'b0;
    endtask

    task automatic fill_key(int i);
        fill(ka(i), kv(i), ko(i), 2'(i));
    endtask

    task automatic inval(logic [1:0] k, logic [15:0] a, logic [63:0] v);
        @(negedge clk);
        inv_valid = 1'b1; inv_kind = k; inv_asid = a; inv_addr = v;
        @(negedge clk);
        inv_valid = 1'b0;
    endtask

    task automatic look(string req, logic [15:0] a, logic [63:0] v, logic eh,
                        logic [63:0] eo, logic [63:0] em, logic [1:0] ep);
        lk_asid = a; lk_addr = v;
        #1;
        checks++;
        if ({lk_hit, lk_out_addr, lk_mask, lk_perm} !== {eh, eo, em, ep}) begin
            fails++;
            $display("FAIL %s: hit=%b out=%h mask=%h perm=%h expected hit=%b out=%h mask=%h perm=%h",
                     req, lk_hit, lk_out_addr, lk_mask, lk_perm, eh, eo, em, ep);
        end
    endtask

    task automatic look_key(string req, int i, logic eh);
        if (eh) look(req, ka(i), kv(i), 1'b1, ko(i), 64'hFFF, 2'(i));
        else    look(req, ka(i), kv(i), 1'b0, '0, '0, '0);
    endtask

    task automatic fill_full();
        for (int i = 0; i < 8; i++) fill_key(i);
    endtask

    task automatic t_reset();
        fill_full();
        do_reset();
        for (int i = 0; i < 8; i++) look_key("R1 reset empties", i, 1'b0);
    endtask

    task automatic t_hit_miss();
        fill_key(2);
        look_key("R2 exact hit", 2, 1'b1);
        look_key("R4 fill visible next edge", 2, 1'b1);
        look("R2 ASID differs", ka(3), kv(2), 1'b0, '0, '0, '0);
        look("R2 address differs", ka(2), kv(2) + 64'h1000, 1'b0, '0, '0, '0);
        look("R3 miss zeroes", ka(2), kv(2) ^ 64'h1, 1'b0, '0, '0, '0);
    endtask

    task automatic t_inv_all();
        do_reset();
        fill_full();
        inval(2'b00, '0, '0);
        for (int i = 0; i < 8; i++) look_key("R5 invalidate all", i, 1'b0);
    endtask

    task automatic t_inv_asid();
        do_reset();
        fill(16'h0050, 64'h1000, 64'h11000, 2'd1);
        fill(16'h0050, 64'h2000, 64'h12000, 2'd2);
        fill(16'h0051, 64'h1000, 64'h13000, 2'd3);
        inval(2'b01, 16'h0050, 64'h9999_0000);
        look("R6 ASID line a gone", 16'h0050, 64'h1000, 1'b0, '0, '0, '0);
        look("R6 ASID line b gone", 16'h0050, 64'h2000, 1'b0, '0, '0, '0);
        look("R6 other ASID kept", 16'h0051, 64'h1000, 1'b1, 64'h13000, 64'hFFF, 2'd3);
    endtask

    task automatic t_inv_pair();
        do_reset();
        fill(16'h0060, 64'h1000, 64'h21000, 2'd1);
        fill(16'h0060, 64'h2000, 64'h22000, 2'd2);
        fill(16'h0061, 64'h1000, 64'h23000, 2'd3);
        inval(2'b10, 16'h0060, 64'h1000);
        look("R7 pair gone", 16'h0060, 64'h1000, 1'b0, '0, '0, '0);
        look("R7 same ASID other addr kept", 16'h0060, 64'h2000, 1'b1, 64'h22000, 64'hFFF, 2'd2);
        look("R7 other ASID same addr kept", 16'h0061, 64'h1000, 1'b1, 64'h23000, 64'hFFF, 2'd3);
        inval(2'b11, 16'h0060, 64'h2000);
        look("R8 kind 11 no effect", 16'h0060, 64'h2000, 1'b1, 64'h22000, 64'hFFF, 2'd2);
        look("R8 kind 11 no effect", 16'h0061, 64'h1000, 1'b1, 64'h23000, 64'hFFF, 2'd3);
    endtask

    task automatic t_overwrite();
        do_reset();
        fill_key(0);
        fill(ka(0), kv(0), 64'hBEEF_0000, 2'd3);
        look("R9 overwrite in place", ka(0), kv(0), 1'b1, 64'hBEEF_0000, 64'hFFF, 2'd3);
        for (int i = 1; i < 8; i++) fill_key(i);
        look("R9 no duplicate line", ka(0), kv(0), 1'b1, 64'hBEEF_0000, 64'hFFF, 2'd3);
        for (int i = 1; i < 8; i++) look_key("R9 others present", i, 1'b1);
    endtask

    task automatic t_free_slot();
        do_reset();
        fill_full();
        inval(2'b10, ka(3), kv(3));
        fill_key(9);
        look_key("R10 fill into hole", 9, 1'b1);
        look_key("R10 hole key gone", 3, 1'b0);
        for (int i = 0; i < 8; i++)
            if (i != 3) look_key("R10 survivors kept", i, 1'b1);
    endtask

    task automatic t_round_robin();
        do_reset();
        fill_full();
        fill_key(8);
        look_key("R11 rr evicts line 0", 0, 1'b0);
        look_key("R11 new key present", 8, 1'b1);
        look_key("R11 line 1 kept", 1, 1'b1);
        fill_key(9);
        look_key("R11 rr advanced to line 1", 1, 1'b0);
        look_key("R11 line 2 kept", 2, 1'b1);
        for (int i = 10; i < 16; i++) fill_key(i);
        fill_key(16);
        look_key("R11 wrap evicts line 0", 8, 1'b0);
        look_key("R11 wrap keeps line 1", 9, 1'b1);
    endtask

    task automatic t_same_cycle();
        do_reset();
        fill_full();
        @(negedge clk);
        inv_valid = 1'b1; inv_kind = 2'b00; inv_asid = '0; inv_addr = '0;
        set_fill(ka(9), kv(9), ko(9), 2'd1);
        @(negedge clk);
        inv_valid = 1'b0; fl_valid = 1'b0;
        look_key("R12 fill survives inv all", 9, 1'b1);
        look_key("R12 old line removed", 0, 1'b0);
        @(negedge clk);
        inv_valid = 1'b1; inv_kind = 2'b10; inv_asid = ka(9); inv_addr = kv(9);
        set_fill(ka(9), kv(9), 64'hCAFE_0000, 2'd2);
        @(negedge clk);
        inv_valid = 1'b0; fl_valid = 1'b0;
        look("R12 pair refilled", ka(9), kv(9), 1'b1, 64'hCAFE_0000, 64'hFFF, 2'd2);
        fill(16'h0077, 64'h5000, 64'h55000, 2'd0);
        @(negedge clk);
        inv_valid = 1'b1; inv_kind = 2'b01; inv_asid = 16'h0077; inv_addr = '0;
        set_fill(16'h0077, 64'h6000, 64'h66000, 2'd3);
        @(negedge clk);
        inv_valid = 1'b0; fl_valid = 1'b0;
        look("R12 ASID inv old line", 16'h0077, 64'h5000, 1'b0, '0, '0, '0);
        look("R12 ASID inv then fill", 16'h0077, 64'h6000, 1'b1, 64'h66000, 64'hFFF, 2'd3);
    endtask

    initial begin
        rst_n = 1'b0; fl_valid = 1'b0; inv_valid = 1'b0; inv_kind = 2'b11;
        fl_asid = '0; fl_addr = '0; fl_out_addr = '0; fl_mask = '0; fl_perm = '0;
        inv_asid = '0; inv_addr = '0; lk_asid = '0; lk_addr = '0;
        do_reset();
        for (int i = 0; i < 4; i++) look_key("R1 empty after reset", i, 1'b0);
        t_hit_miss();
        t_reset();
        t_inv_all();
        t_inv_asid();
        t_inv_pair();
        t_overwrite();
        t_free_slot();
        t_round_robin();
        t_same_cycle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (WD) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule